// File: doc/BRIEF.md
# Channel-Aware Transmit Sample FIFO

This block buffers 24-bit audio sample words between a processor register bus and an audio serializer. Software fills it through one of two data registers: one takes a full 24-bit word, the other takes a 16-bit sample and left-justifies it. The serializer drains one word per channel slot through a valid/ready stream. The storage holds `256 << RAM_CODE` words. The number of words that may be held at once depends on the configured channel count. The capacity is divided by the channel count rounded up to a power of two, and the result is multiplied back by the real channel count. For example, three channels use the four-channel depth.

A status register reports how many whole channel-frames are buffered. It also carries two sticky error flags, one for writes rejected because the FIFO is full and one for pops attempted while it is empty. Both flags clear on a write of zero. A control register gives a one-shot clear of the buffered data and an enable for an interrupt request that is raised while the fill level is at or below half of the usable word capacity.

Stream rules: `pop_valid` is high exactly while at least one word is buffered. A word leaves on a clock edge where both `pop_valid` and `pop_ready` are high. The serializer may hold `pop_ready` high while `pop_valid` is low. Each such cycle counts as an underrun and presents a zero word. The bus side has no back-pressure: a data write that finds the FIFO at its limit is dropped and flagged.

Top module: `chan_sample_fifo`

## Requirements
- R1: With channel code c (channels n = c+1), the FIFO accepts exactly (256 << RAM_CODE) >> k words times n, where k is the smallest value with 2^k >= n. With RAM_CODE = 0 the limits are 1ch 256, 2ch 256, 3ch 192, 4ch 256, 5ch 160, 6ch 192, 8ch 256 words.
- R2: A data write arriving while the FIFO holds its limit is discarded and sets a sticky overrun flag at status bit 4.
- R3: A pop request (`pop_ready` high) while empty sets a sticky underrun flag at status bit 0, and in that cycle `pop_data` is zero.
- R4: A status write (address 1) clears each flag whose written bit is 0 and keeps it when the bit is 1. No other access clears a flag.
- R5: Status bits 16:8 read the buffered word count divided by the channel count, rounded down.
- R6: A write to the 24-bit data register (address 2) stores bits 23:0 of the bus word and ignores bits 31:24.
- R7: A write to the 16-bit data register (address 3) stores bits 15:0 of the bus word at word bits 23:8, with bits 7:0 zero.
- R8: Words leave in the order written. `pop_valid` is high exactly while at least one word is held.
- R9: Writing control (address 0) with bit 0 set empties the FIFO by the next cycle and leaves both flags unchanged. Control bit 0 always reads 0.
- R10: Control bit 20 is a stored, readable enable. `irq` is high when it is set and the fill level is at most half of the R1 limit (rounded down).
- R11: After reset the FIFO is empty, both flags and the enable are 0, and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_code | input | 3 | Channel count minus one |
| bus_wen | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register select: 0 control, 1 status, 2 data24, 3 data16 |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for `bus_addr` (data registers read 0) |
| pop_ready | input | 1 | Serializer requests a word |
| pop_valid | output | 1 | A word is available |
| pop_data | output | 24 | Head word, zero when empty |
| irq | output | 1 | Half-level interrupt request |

## Verification
Register effects land on the first rising edge after a write: fill level, flags, enable and `irq` all change at that edge. `bus_rdata`, `pop_valid` and `pop_data` follow the current state combinationally, so a read or pop result is valid in the same cycle it is requested. The bench changes inputs at the falling edge. It samples the combinational outputs one time unit later. It samples the registered effects at the next falling edge, half a period after the edge that updates them, so every check lands after exactly one register stage.

// File: rtl/csf_pkg.sv
package csf_pkg;
  localparam int SAMPLE_W      = 24;
  localparam int BUS_W         = 32;
  localparam int CTRL_CLR_BIT  = 0;
  localparam int CTRL_HALF_BIT = 20;
  localparam int STAT_UND_BIT  = 0;
  localparam int STAT_OVR_BIT  = 4;
  localparam int RES_LSB       = 8;
  localparam int RES_W         = 9;
  localparam int NARROW_W      = 16;

  typedef enum logic [1:0] {
    REG_CTRL   = 2'd0,
    REG_STAT   = 2'd1,
    REG_DATA   = 2'd2,
    REG_DATA16 = 2'd3
  } csf_reg_e;

  // Number of halvings needed so that 2**shift >= channels (code = channels-1)
  function automatic int unsigned chan_shift(input logic [2:0] code);
    int unsigned s;
    s = 0;
    for (int unsigned p = 1; p < 32'(code) + 1; p = p << 1) s++;
    return s;
  endfunction
endpackage

// File: rtl/csf_store.sv
module csf_store #(
  parameter int DW = 24,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/csf_limit.sv
module csf_limit import csf_pkg::*; #(
  parameter int CAP = 256,
  parameter int FW  = 9
) (
  input  logic [2:0]    chan_code,
  output logic [3:0]    chans,
  output logic [FW-1:0] limit_words,
  output logic [FW-1:0] half_words
);
  int unsigned per_chan;

  always_comb begin
    chans       = 4'(chan_code) + 4'd1;
    per_chan    = 32'(CAP) >> chan_shift(chan_code);
    limit_words = FW'(per_chan * 32'(chans));
    half_words  = limit_words >> 1;
  end
endmodule

// File: rtl/csf_frame_div.sv
module csf_frame_div #(
  parameter int FW = 9
) (
  input  logic [FW-1:0] num,
  input  logic [3:0]    den,
  output logic [FW-1:0] quo
);
  logic [FW:0] rem;

  // Restoring division, one quotient bit per stage
  always_comb begin
    rem = '0;
    quo = '0;
    for (int i = FW - 1; i >= 0; i--) begin
      rem = {rem[FW-1:0], num[i]};
      if (rem >= (FW+1)'(den)) begin
        rem    = rem - (FW+1)'(den);
        quo[i] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/chan_sample_fifo.sv
module chan_sample_fifo import csf_pkg::*; #(
  parameter int RAM_CODE = 0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [2:0]          chan_code,
  input  logic                bus_wen,
  input  logic [1:0]          bus_addr,
  input  logic [BUS_W-1:0]    bus_wdata,
  output logic [BUS_W-1:0]    bus_rdata,
  input  logic                pop_ready,
  output logic                pop_valid,
  output logic [SAMPLE_W-1:0] pop_data,
  output logic                irq
);
  localparam int CAP = 256 << RAM_CODE;
  localparam int AW  = $clog2(CAP);
  localparam int FW  = AW + 1;

  csf_reg_e            reg_sel;
  logic [FW-1:0]       fill_words, limit_words, half_words, frames;
  logic [3:0]          chans;
  logic [AW-1:0]       wptr, rptr;
  logic                ovr_q, und_q, irq_en_q;
  logic                wr_word, clr_pulse, ctrl_wr, stat_wr;
  logic                push, pop_fire, ovf_evt, udf_evt;
  logic [SAMPLE_W-1:0] wr_sample, rd_sample;

  assign reg_sel   = csf_reg_e'(bus_addr);
  assign wr_word   = bus_wen && (reg_sel == REG_DATA || reg_sel == REG_DATA16);
  assign ctrl_wr   = bus_wen && reg_sel == REG_CTRL;
  assign stat_wr   = bus_wen && reg_sel == REG_STAT;
  assign clr_pulse = ctrl_wr && bus_wdata[CTRL_CLR_BIT];

  // Word formatting: narrow samples are left-justified
  always_comb begin
    if (reg_sel == REG_DATA16)
      wr_sample = {bus_wdata[NARROW_W-1:0], {(SAMPLE_W-NARROW_W){1'b0}}};
    else
      wr_sample = bus_wdata[SAMPLE_W-1:0];
  end

  csf_limit #(.CAP(CAP), .FW(FW)) u_limit (
    .chan_code   (chan_code),
    .chans       (chans),
    .limit_words (limit_words),
    .half_words  (half_words)
  );

  csf_frame_div #(.FW(FW)) u_div (
    .num (fill_words),
    .den (chans),
    .quo (frames)
  );

  assign pop_valid = fill_words != '0;
  assign push      = wr_word && (fill_words < limit_words);
  assign ovf_evt   = wr_word && (fill_words >= limit_words);
  assign pop_fire  = pop_ready && pop_valid;
  assign udf_evt   = pop_ready && !pop_valid;

  csf_store #(.DW(SAMPLE_W), .AW(AW)) u_store (
    .clk   (clk),
    .we    (push),
    .waddr (wptr),
    .wdata (wr_sample),
    .raddr (rptr),
    .rdata (rd_sample)
  );

  assign pop_data = pop_valid ? rd_sample : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr       <= '0;
      rptr       <= '0;
      fill_words <= '0;
      ovr_q      <= 1'b0;
      und_q      <= 1'b0;
      irq_en_q   <= 1'b0;
    end else begin
      if (clr_pulse) begin
        wptr       <= '0;
        rptr       <= '0;
        fill_words <= '0;
      end else begin
        if (push)     wptr <= wptr + 1'b1;
        if (pop_fire) rptr <= rptr + 1'b1;
        fill_words <= fill_words + FW'(push) - FW'(pop_fire);
      end
      if (ctrl_wr) irq_en_q <= bus_wdata[CTRL_HALF_BIT];
      ovr_q <= (ovr_q & ~(stat_wr & ~bus_wdata[STAT_OVR_BIT])) | ovf_evt;
      und_q <= (und_q & ~(stat_wr & ~bus_wdata[STAT_UND_BIT])) | udf_evt;
    end
  end

  assign irq = irq_en_q && (fill_words <= half_words);

  always_comb begin
    bus_rdata = '0;
    case (reg_sel)
      REG_CTRL: bus_rdata[CTRL_HALF_BIT] = irq_en_q;
      REG_STAT: begin
        bus_rdata[RES_LSB +: RES_W] = RES_W'(frames);
        bus_rdata[STAT_OVR_BIT]     = ovr_q;
        bus_rdata[STAT_UND_BIT]     = und_q;
      end
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/csf_checker.sv
module csf_checker #(
  parameter int FW = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_word,
  input logic          clr_pulse,
  input logic [FW-1:0] fill_words,
  input logic [FW-1:0] limit_words,
  input logic          ovr_q,
  input logic          und_q,
  input logic          irq_en_q,
  input logic          pop_ready,
  input logic          pop_valid,
  input logic [23:0]   pop_data,
  input logic          irq
);
  // R2
  ovr_flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_word && fill_words >= limit_words) |=> ovr_q);

  // R2
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_word && fill_words >= limit_words && !pop_ready && !clr_pulse) |=> $stable(fill_words));

  // R3
  und_zero_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_ready && !pop_valid) |-> pop_data == 24'd0);

  // R3
  und_flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_ready && !pop_valid) |=> und_q);

  // R9
  clr_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_pulse |=> !pop_valid);

  // R9
  clr_keeps_ovr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_pulse |=> ovr_q == $past(ovr_q));

  // R10
  irq_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en_q && !pop_valid) |-> irq);
endmodule

bind chan_sample_fifo csf_checker #(.FW(FW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_word     (wr_word),
  .clr_pulse   (clr_pulse),
  .fill_words  (fill_words),
  .limit_words (limit_words),
  .ovr_q       (ovr_q),
  .und_q       (und_q),
  .irq_en_q    (irq_en_q),
  .pop_ready   (pop_ready),
  .pop_valid   (pop_valid),
  .pop_data    (pop_data),
  .irq         (irq)
);

// File: tb/chan_sample_fifo_test.sv
module chan_sample_fifo_test;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 7;
  // {chan_code[2:0], limit_words[9:0], frames_at_limit[8:0]}
  localparam logic [21:0] VEC [NVEC] = '{
    {3'd0, 10'd256, 9'd256},
    {3'd1, 10'd256, 9'd128},
    {3'd2, 10'd192, 9'd64},
    {3'd3, 10'd256, 9'd64},
    {3'd4, 10'd160, 9'd32},
    {3'd5, 10'd192, 9'd32},
    {3'd7, 10'd256, 9'd32}
  };

  logic        clk = 0;
  logic        rst_n = 0;
  logic [2:0]  chan_code = 0;
  logic        bus_wen = 0;
  logic [1:0]  bus_addr = 2'd1;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic        pop_ready = 0;
  logic        pop_valid;
  logic [23:0] pop_data;
  logic        irq;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  chan_sample_fifo uut (
    .clk(clk), .rst_n(rst_n), .chan_code(chan_code),
    .bus_wen(bus_wen), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .pop_ready(pop_ready), .pop_valid(pop_valid),
    .pop_data(pop_data), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
    bus_wen = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wen = 0; bus_addr = 2'd1;
  endtask

  task automatic read_reg(input logic [1:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
    bus_addr = 2'd1;
  endtask

  task automatic pop_one(output logic [23:0] d, output logic v);
    pop_ready = 1;
    #1 d = pop_data; v = pop_valid;
    @(negedge clk);
    pop_ready = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    logic [31:0] r;
    logic [23:0] d;
    logic        v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R11 reset state
    read_reg(2'd1, r); check("R11 status", r, 32'h0);
    read_reg(2'd0, r); check("R11 ctrl", r, 32'h0);
    check("R11 valid", {31'd0, pop_valid}, 32'd0);
    check("R11 irq", {31'd0, irq}, 32'd0);

    // Table walk: R1 limit, R2 overrun, R5 residue, R4 clear
    for (int e = 0; e < NVEC; e++) begin
      int lim;
      int frm;
      lim = int'(VEC[e][18:9]);
      frm = int'(VEC[e][8:0]);
      chan_code = VEC[e][21:19];
      bus_write(2'd0, 32'h1);
      bus_write(2'd1, 32'h0);
      for (int i = 0; i < lim; i++) bus_write(2'd2, 32'h100 + i);
      read_reg(2'd1, r);
      check("R1 R5 residue at limit, no overrun", r, 32'(frm) << 8);
      bus_write(2'd2, 32'hABCDEF);
      read_reg(2'd1, r);
      check("R2 overrun flag, write dropped", r, (32'(frm) << 8) | 32'h10);
      pop_one(d, v);
      check("R1 head word", {7'd0, v, d}, {7'd0, 1'b1, 24'h100});
      bus_write(2'd1, 32'h0);
      read_reg(2'd1, r);
      check("R4 flags cleared", r & 32'h11, 32'h0);
    end
    bus_write(2'd0, 32'h1);

    // R5 partial frame: 2 channels, 5 words -> 2 frames
    chan_code = 3'd1;
    for (int i = 0; i < 5; i++) bus_write(2'd2, 32'h0);
    read_reg(2'd1, r); check("R5 partial frame", r, 32'h200);
    bus_write(2'd0, 32'h1);
    chan_code = 3'd0;

    // R6, R7, R8 formatting and order
    bus_write(2'd2, 32'hAB123456);
    bus_write(2'd3, 32'hFFFFBEEF);
    bus_write(2'd2, 32'h00000777);
    pop_one(d, v); check("R6 upper bits dropped", {8'd0, d}, 32'h123456);
    pop_one(d, v); check("R7 narrow left-justified", {8'd0, d}, 32'hBEEF00);
    pop_one(d, v); check("R8 order third word", {8'd0, d}, 32'h000777);
    check("R8 empty after drain", {31'd0, pop_valid}, 32'd0);

    // R3 underrun
    pop_one(d, v);
    check("R3 zero word on empty", {7'd0, v, d}, 32'd0);
    read_reg(2'd1, r); check("R3 underrun flag", r, 32'h1);
    // R4 write-one keeps, write-zero clears
    bus_write(2'd1, 32'h11);
    read_reg(2'd1, r); check("R4 write one keeps", r, 32'h1);

    // R9 clear keeps flags, empties
    for (int i = 0; i < 5; i++) bus_write(2'd2, 32'h55);
    bus_write(2'd0, 32'h1);
    read_reg(2'd1, r); check("R9 empty, flag kept", r, 32'h1);
    check("R9 valid low", {31'd0, pop_valid}, 32'd0);
    read_reg(2'd0, r); check("R9 clear bit not stored", r, 32'h0);
    bus_write(2'd1, 32'h0);
    read_reg(2'd1, r); check("R4 write zero clears", r, 32'h0);

    // R10 half-level interrupt, 1 channel: limit 256, half 128
    bus_write(2'd0, 32'h100000);
    read_reg(2'd0, r); check("R10 enable readback", r, 32'h100000);
    check("R10 irq empty", {31'd0, irq}, 32'd1);
    for (int i = 0; i < 128; i++) bus_write(2'd2, 32'h1);
    check("R10 irq at half", {31'd0, irq}, 32'd1);
    bus_write(2'd2, 32'h1);
    check("R10 irq above half", {31'd0, irq}, 32'd0);
    pop_one(d, v);
    check("R10 irq back at half", {31'd0, irq}, 32'd1);
    bus_write(2'd0, 32'h0);
    check("R10 irq disabled", {31'd0, irq}, 32'd0);

    finish_run();
  end
endmodule